// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block draws a 64x64 pixel, two-bit-per-pixel pointer sprite on top of a raster pixel stream. Software programs the sprite's screen position, a hot-spot preset, a control byte and the base of the 1 KiB pattern region through a byte-wide register port. For every pixel of the raster, the block reports one of four codes: cursor colour 0, cursor colour 1, transparent (the frame pixel passes through), or invert (the frame pixel is inverted). For the two colour codes, it also supplies the RGB value from its own two-entry palette.

Pattern memory is read only during horizontal blanking. A line-start pulse starts a burst of sixteen byte reads into a one-line buffer. The pixel stage then reads only that buffer. The hot-spot preset skips the first pattern columns and rows, so a cursor whose hot spot sits near the top or left screen edge can be clipped. Position and preset writes are held in shadow registers and take effect at the next frame boundary. A control bit steers writes on the shared palette data port either to the cursor palette or onward to the main palette.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_code` is 2'b10 (transparent), `cur_rgb` is zero, and `mem_rd` and `main_pal_we` are low.
- R2: When `line_start` is sampled with the cursor visible and `pix_y` inside the cursor's rows, exactly 16 consecutive read cycles follow, starting the next cycle. Each read address is {base[11:0], row[5:0], byte[3:0]}, with the byte index counting 0 to 15. Here row = pix_y - vstart + vpreset.
- R3: No read is issued for a line outside the cursor's rows, or while the visible bit is clear.
- R4: One cycle after `pix_x` is presented, `pix_code` gives the pattern code for column c. The code is taken from byte c/4, and the leftmost pixel of each byte is bits [7:6]. Codes: 00 = colour 0, 01 = colour 1, 10 = transparent, 11 = invert.
- R5: Pixels left of the horizontal start, or past the cursor's right extent, are transparent. This holds up to the last pixel column (2047).
- R6: The horizontal and vertical presets (0 to 63) skip that many pattern columns and rows. The displayed width is then extent - preset, and likewise for the height.
- R7: Control bit 1 set gives a 64x64 extent. Control bit 1 clear limits the extent to the first 32 columns and 32 rows of the pattern.
- R8: Writes to start position and preset registers take effect only at `frame_start`. A write in the same cycle as `frame_start` is included.
- R9: With control bit 0 (visible) clear, every pixel is transparent.
- R10: With control bit 2 set, a palette write loads cursor palette entry `pal_sel` and `main_pal_we` stays low. With bit 2 clear, the write goes to `main_pal_we` and the cursor palette is unchanged. `cur_rgb` is the selected entry for codes 00 and 01, and zero otherwise.
- R11: When `active` is low, the pixel is transparent.

Register indices on `reg_addr`:
- 0: horizontal start, bits [7:0]
- 1: horizontal start, bits [10:8] (from wdata [2:0])
- 2: horizontal preset [5:0]
- 3: vertical start, bits [7:0]
- 4: vertical start, bits [10:8] (from wdata [2:0])
- 5: vertical preset [5:0]
- 6: control [2:0]
- 7: pattern base, bits [7:0]
- 8: pattern base, bits [11:8] (from wdata [3:0])

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| pal_we | input | 1 | Palette data-port write strobe |
| pal_sel | input | 1 | Cursor palette entry select |
| pal_wdata | input | 24 | Palette RGB write data |
| main_pal_we | output | 1 | Palette write forwarded to the main palette |
| frame_start | input | 1 | Frame boundary pulse; loads the shadow registers |
| line_start | input | 1 | Blanking pulse; `pix_y` then holds the next line |
| active | input | 1 | Active display enable |
| pix_x | input | 11 | Current pixel column |
| pix_y | input | 11 | Line number |
| mem_rd | output | 1 | Pattern read request |
| mem_addr | output | 22 | Pattern byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pix_code | output | 2 | Per-pixel cursor code |
| cur_rgb | output | 24 | Cursor colour for codes 00 and 01 |

## Verification
A register write and the frame boundary can land in the same cycle. The shadow copy must then capture the value being written, not the old one. The bench first writes a new horizontal start with no frame pulse and checks that the raster still uses the old start. It then asserts `reg_we` and `frame_start` together and judges the following line pixel by pixel against the newly written start. Palette routing and pixel colour output are also checked together, since each swept pixel compares `cur_rgb` against palette entries written earlier in routed mode. A write made in unrouted mode must leave those entries intact.

// File: rtl/cursor_pkg.sv
// Package: shared codes and register indices for the cursor overlay.
// Assumes a byte-wide register port with a 4-bit index.
package cursor_pkg;
    typedef enum logic [1:0] {
        PC_COL0   = 2'b00,
        PC_COL1   = 2'b01,
        PC_CLEAR  = 2'b10,
        PC_INVERT = 2'b11
    } pix_code_e;

    localparam logic [3:0] RA_HS_LO   = 4'd0;
    localparam logic [3:0] RA_HS_HI   = 4'd1;
    localparam logic [3:0] RA_HPRE    = 4'd2;
    localparam logic [3:0] RA_VS_LO   = 4'd3;
    localparam logic [3:0] RA_VS_HI   = 4'd4;
    localparam logic [3:0] RA_VPRE    = 4'd5;
    localparam logic [3:0] RA_CTRL    = 4'd6;
    localparam logic [3:0] RA_BASE_LO = 4'd7;
    localparam logic [3:0] RA_BASE_HI = 4'd8;
endpackage

// File: rtl/cursor_regs.sv
// Module: cursor_regs
// Holds the live cursor registers, the frame-aligned shadow copies of
// position and preset, and the two-entry cursor palette. Assumes
// POS_W and BASE_W are both at least 9, so each has a high register.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int BASE_W = 12,
    parameter int RGB_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              frame_start,
    input  logic              pal_we,
    input  logic              pal_sel,
    input  logic [RGB_W-1:0]  pal_wdata,
    output logic [POS_W-1:0]  sh_hs,
    output logic [POS_W-1:0]  sh_vs,
    output logic [PRE_W-1:0]  sh_hp,
    output logic [PRE_W-1:0]  sh_vp,
    output logic              vis,
    output logic              big,
    output logic [BASE_W-1:0] base,
    output logic [RGB_W-1:0]  pal0,
    output logic [RGB_W-1:0]  pal1,
    output logic              main_pal_we
);
    logic [POS_W-1:0]  hs_q, vs_q, hs_n, vs_n;
    logic [PRE_W-1:0]  hp_q, vp_q, hp_n, vp_n;
    logic [2:0]        ctrl_q, ctrl_n;
    logic [BASE_W-1:0] base_q, base_n;
    logic [RGB_W-1:0]  pal_q [2];

    // Next value of every live register, including this cycle's write.
    always_comb begin
        hs_n = hs_q; vs_n = vs_q; hp_n = hp_q; vp_n = vp_q;
        ctrl_n = ctrl_q; base_n = base_q;
        if (reg_we) begin
            case (reg_addr)
                RA_HS_LO:   hs_n[7:0]        = reg_wdata;
                RA_HS_HI:   hs_n[POS_W-1:8]  = reg_wdata[POS_W-9:0];
                RA_HPRE:    hp_n             = reg_wdata[PRE_W-1:0];
                RA_VS_LO:   vs_n[7:0]        = reg_wdata;
                RA_VS_HI:   vs_n[POS_W-1:8]  = reg_wdata[POS_W-9:0];
                RA_VPRE:    vp_n             = reg_wdata[PRE_W-1:0];
                RA_CTRL:    ctrl_n           = reg_wdata[2:0];
                RA_BASE_LO: base_n[7:0]      = reg_wdata;
                RA_BASE_HI: base_n[BASE_W-1:8] = reg_wdata[BASE_W-9:0];
                default: ;
            endcase
        end
    end

    // Live registers follow writes; shadows reload at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '0; vs_q <= '0; hp_q <= '0; vp_q <= '0;
            ctrl_q <= '0; base_q <= '0;
            sh_hs <= '0; sh_vs <= '0; sh_hp <= '0; sh_vp <= '0;
        end else begin
            hs_q <= hs_n; vs_q <= vs_n; hp_q <= hp_n; vp_q <= vp_n;
            ctrl_q <= ctrl_n; base_q <= base_n;
            if (frame_start) begin
                sh_hs <= hs_n; sh_vs <= vs_n; sh_hp <= hp_n; sh_vp <= vp_n;
            end
        end
    end

    // Cursor palette loads only when the data port is routed to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q[0] <= '0;
            pal_q[1] <= '0;
        end else if (pal_we && ctrl_q[2]) begin
            pal_q[pal_sel] <= pal_wdata;
        end
    end

    assign vis         = ctrl_q[0];
    assign big         = ctrl_q[1];
    assign base        = base_q;
    assign pal0        = pal_q[0];
    assign pal1        = pal_q[1];
    assign main_pal_we = pal_we & ~ctrl_q[2];

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> ($stable(sh_hs) && $stable(sh_vp)));
    // R10
    pal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pal_we && ctrl_q[2]) |-> ($stable(pal0) && $stable(pal1)));
endmodule

// File: rtl/cursor_fetch.sv
// Module: cursor_fetch
// On a line-start pulse, decides whether the upcoming line crosses the
// cursor. If it does, reads that pattern row into a one-line buffer,
// one byte per cycle. Assumes read data returns one cycle after the
// request, with no stall.
module cursor_fetch #(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int BASE_W = 12,
    parameter int DATA_W = 8,
    localparam int SIZE   = 1 << PRE_W,
    localparam int NBYTES = SIZE * 2 / DATA_W,
    localparam int IDX_W  = $clog2(NBYTES),
    localparam int ADDR_W = BASE_W + PRE_W + IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  logic [POS_W-1:0]              pix_y,
    input  logic [POS_W-1:0]              sh_vs,
    input  logic [PRE_W-1:0]              sh_vp,
    input  logic                          vis,
    input  logic                          big,
    input  logic [BASE_W-1:0]             base,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          mem_rd,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          row_hit,
    output logic [NBYTES-1:0][DATA_W-1:0] lbuf
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    logic [POS_W:0]   dy, row_sum;
    logic [PRE_W:0]   ext;
    logic             hit_now, busy, rd_d;
    logic [IDX_W-1:0] cnt, idx_d;
    logic [PRE_W-1:0] row_q;

    // Row of the pattern that the upcoming line shows, and whether it exists.
    always_comb begin
        ext     = big ? (PRE_W+1)'(SIZE) : (PRE_W+1)'(SIZE / 2);
        dy      = {1'b0, pix_y} - {1'b0, sh_vs};
        row_sum = {1'b0, dy[POS_W-1:0]} + (POS_W+1)'(sh_vp);
        hit_now = vis && !dy[POS_W] && (row_sum < (POS_W+1)'(ext));
    end

    // Burst sequencer: sixteen reads after a hitting line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cnt <= '0; row_q <= '0; row_hit <= 1'b0;
        end else if (!vis) begin
            busy <= 1'b0; row_hit <= 1'b0;
        end else if (line_start) begin
            busy <= hit_now; cnt <= '0;
            row_q <= row_sum[PRE_W-1:0]; row_hit <= hit_now;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) busy <= 1'b0;
        end
    end

    // Line buffer capture, one cycle behind each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d <= 1'b0; idx_d <= '0; lbuf <= '0;
        end else begin
            rd_d  <= mem_rd;
            idx_d <= cnt;
            if (rd_d) lbuf[idx_d] <= mem_rdata;
        end
    end

    assign mem_rd   = busy;
    assign mem_addr = {base, row_q, cnt};

    // R3
    no_fetch_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vis && $past(!vis)) |-> !mem_rd);
    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && cnt == LAST && !line_start) |=> !mem_rd);
    // R2
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && !$past(line_start)) |->
        (mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]) + 1'b1));
endmodule

// File: rtl/cursor_pixel.sv
// Module: cursor_pixel
// Per-pixel stage: window test, column select from the line buffer,
// and the registered code and colour. Assumes the line buffer holds
// the current line's row whenever row_hit is set.
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int DATA_W = 8,
    parameter int RGB_W  = 24,
    localparam int SIZE   = 1 << PRE_W,
    localparam int NBYTES = SIZE * 2 / DATA_W,
    localparam int PPB    = DATA_W / 2,
    localparam int SUB_W  = $clog2(PPB)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [POS_W-1:0]              pix_x,
    input  logic                          active,
    input  logic [POS_W-1:0]              sh_hs,
    input  logic [PRE_W-1:0]              sh_hp,
    input  logic                          vis,
    input  logic                          big,
    input  logic                          row_hit,
    input  logic [NBYTES-1:0][DATA_W-1:0] lbuf,
    input  logic [RGB_W-1:0]              pal0,
    input  logic [RGB_W-1:0]              pal1,
    output logic [1:0]                    pix_code,
    output logic [RGB_W-1:0]              cur_rgb
);
    logic [POS_W:0]     dx, col_sum;
    logic [PRE_W:0]     ext;
    logic [PRE_W-1:0]   col;
    logic [DATA_W-1:0]  byte_v;
    logic [SUB_W:0]     shift;
    logic               in_win;
    pix_code_e          code_c;

    // Column inside the pattern and the two-bit code found there.
    always_comb begin
        ext     = big ? (PRE_W+1)'(SIZE) : (PRE_W+1)'(SIZE / 2);
        dx      = {1'b0, pix_x} - {1'b0, sh_hs};
        col_sum = {1'b0, dx[POS_W-1:0]} + (POS_W+1)'(sh_hp);
        in_win  = !dx[POS_W] && (col_sum < (POS_W+1)'(ext));
        col     = col_sum[PRE_W-1:0];
        byte_v  = lbuf[col[PRE_W-1:SUB_W]];
        shift   = (SUB_W+1)'((PPB - 1 - int'(col[SUB_W-1:0])) * 2);
        code_c  = pix_code_e'(2'(byte_v >> shift));
    end

    // Output register: code and matching palette colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_code <= PC_CLEAR;
            cur_rgb  <= '0;
        end else if (vis && active && row_hit && in_win) begin
            pix_code <= code_c;
            case (code_c)
                PC_COL0: cur_rgb <= pal0;
                PC_COL1: cur_rgb <= pal1;
                default: cur_rgb <= '0;
            endcase
        end else begin
            pix_code <= PC_CLEAR;
            cur_rgb  <= '0;
        end
    end

    // R11
    blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (pix_code == PC_CLEAR));
    // R9
    hidden_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vis) |-> (pix_code == PC_CLEAR));
    // R10
    rgb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_code[1] |-> (cur_rgb == '0));
endmodule

// File: rtl/cursor_overlay.sv
// Module: cursor_overlay (top)
// Hardware cursor sprite overlay: registers, line fetcher and pixel stage.
// Assumes line_start falls in horizontal blanking with pix_y holding the
// line about to be shown, and that blanking lasts at least 18 cycles.
module cursor_overlay #(
    parameter int POS_W  = 11,
    parameter int PRE_W  = 6,
    parameter int BASE_W = 12,
    parameter int DATA_W = 8,
    parameter int RGB_W  = 24,
    localparam int SIZE   = 1 << PRE_W,
    localparam int NBYTES = SIZE * 2 / DATA_W,
    localparam int ADDR_W = BASE_W + PRE_W + $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              pal_we,
    input  logic              pal_sel,
    input  logic [RGB_W-1:0]  pal_wdata,
    output logic              main_pal_we,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              active,
    input  logic [POS_W-1:0]  pix_x,
    input  logic [POS_W-1:0]  pix_y,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        pix_code,
    output logic [RGB_W-1:0]  cur_rgb
);
    logic [POS_W-1:0]              sh_hs, sh_vs;
    logic [PRE_W-1:0]              sh_hp, sh_vp;
    logic                          vis, big, row_hit;
    logic [BASE_W-1:0]             base;
    logic [RGB_W-1:0]              pal0, pal1;
    logic [NBYTES-1:0][DATA_W-1:0] lbuf;

    cursor_regs #(.POS_W(POS_W), .PRE_W(PRE_W), .BASE_W(BASE_W), .RGB_W(RGB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .pal_we(pal_we),
        .pal_sel(pal_sel), .pal_wdata(pal_wdata), .sh_hs(sh_hs), .sh_vs(sh_vs),
        .sh_hp(sh_hp), .sh_vp(sh_vp), .vis(vis), .big(big), .base(base),
        .pal0(pal0), .pal1(pal1), .main_pal_we(main_pal_we)
    );

    cursor_fetch #(.POS_W(POS_W), .PRE_W(PRE_W), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_y(pix_y),
        .sh_vs(sh_vs), .sh_vp(sh_vp), .vis(vis), .big(big), .base(base),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .row_hit(row_hit), .lbuf(lbuf)
    );

    cursor_pixel #(.POS_W(POS_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .RGB_W(RGB_W)) u_pixel (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .active(active),
        .sh_hs(sh_hs), .sh_hp(sh_hp), .vis(vis), .big(big), .row_hit(row_hit),
        .lbuf(lbuf), .pal0(pal0), .pal1(pal1), .pix_code(pix_code),
        .cur_rgb(cur_rgb)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (pix_code == 2'b10 && !mem_rd));
endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        pal_we = 1'b0;
    logic        pal_sel = 1'b0;
    logic [23:0] pal_wdata = '0;
    logic        main_pal_we;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        active = 1'b0;
    logic [10:0] pix_x = '0;
    logic [10:0] pix_y = '0;
    logic        mem_rd;
    logic [21:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [1:0]  pix_code;
    logic [23:0] cur_rgb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // expected state, tracked from the requirements
    int e_hs, e_vs, e_hp, e_vp, e_ctrl, e_base;
    int p_hs, p_vs, p_hp, p_vp;
    localparam int PAL0 = 24'h123456;
    localparam int PAL1 = 24'hABCDEF;

    // read log
    int rd_total = 0;
    int rd_log [64];

    always #2.5 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pal_we(pal_we), .pal_sel(pal_sel),
        .pal_wdata(pal_wdata), .main_pal_we(main_pal_we),
        .frame_start(frame_start), .line_start(line_start), .active(active),
        .pix_x(pix_x), .pix_y(pix_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pix_code(pix_code), .cur_rgb(cur_rgb)
    );

    function automatic int patf(int a);
        return (((a & 255) * 29) ^ (a >> 8) ^ (a >> 14)) & 255;
    endfunction

    // pattern memory, one cycle latency
    always @(posedge clk) if (mem_rd) mem_rdata <= 8'(patf(int'(mem_addr)));

    // log read addresses between edges
    always @(negedge clk) if (mem_rd) begin
        rd_log[rd_total % 64] = int'(mem_addr);
        rd_total = rd_total + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_code(int x, int y, bit act);
        int ext, dx, dy, r, c, b;
        if (!e_ctrl[0] || !act) return 2;
        ext = e_ctrl[1] ? 64 : 32;
        dx = x - e_hs; dy = y - e_vs;
        if (dx < 0 || dy < 0) return 2;
        r = dy + e_vp; c = dx + e_hp;
        if (r >= ext || c >= ext) return 2;
        b = patf(e_base * 1024 + r * 16 + c / 4);
        return (b >> (6 - 2 * (c % 4))) & 3;
    endfunction

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // write live registers, then a frame pulse loads the shadows
    task automatic setup(input int hs, vs, hp, vp, ctrl, base);
        wr(0, hs & 255); wr(1, hs >> 8); wr(2, hp);
        wr(3, vs & 255); wr(4, vs >> 8); wr(5, vp);
        wr(6, ctrl); wr(7, base & 255); wr(8, base >> 8);
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        e_hs = hs; e_vs = vs; e_hp = hp; e_vp = vp; e_ctrl = ctrl; e_base = base;
    endtask

    // line start, then check the read burst
    task automatic do_line(input int y);
        int s, n, ext, r, want;
        bit hit;
        s = rd_total;
        pix_y = 11'(y); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (20) @(negedge clk);
        n = rd_total - s;
        ext = e_ctrl[1] ? 64 : 32;
        r = y - e_vs + e_vp;
        hit = e_ctrl[0] && (y >= e_vs) && (r < ext);
        want = hit ? 16 : 0;
        chk(n == want, hit ? "R2 read count" : "R3 no reads", n, want);
        if (hit && n == 16)
            for (int k = 0; k < 16; k++)
                chk(rd_log[(s + k) % 64] == e_base * 1024 + r * 16 + k,
                    "R2 read address", rd_log[(s + k) % 64], e_base * 1024 + r * 16 + k);
    endtask

    // present pixels and check code and colour one cycle later
    task automatic sweep(input int x0, input int n, input int y, input bit act, input string req);
        int ec, er;
        for (int i = 0; i < n; i++) begin
            pix_x = 11'(x0 + i); active = act;
            @(negedge clk);
            ec = exp_code(x0 + i, y, act);
            er = (ec == 0) ? PAL0 : (ec == 1) ? PAL1 : 0;
            chk(pix_code == 2'(ec), req, int'(pix_code), ec);
            chk(cur_rgb == 24'(er), "R10 colour", int'(cur_rgb), er);
        end
        active = 1'b0;
        @(negedge clk);
    endtask

    // hs, vs, hp, vp, ctrl, base, line, x0, n
    localparam int VEC [9][9] = '{
        '{100,   50,  0,  0, 3,    5,   50,   90, 80},
        '{100,   50,  0,  0, 3,    5,  113,  150, 20},
        '{100,   50,  0,  0, 3,    5,  114,   95, 40},
        '{100,   50,  0,  0, 3,    5,   49,   95, 40},
        '{  0,    0, 10, 20, 3,  700,   43,    0, 60},
        '{200,   10,  0,  0, 1, 4095,   41,  190, 50},
        '{200,   10,  0,  0, 1, 4095,   42,  190, 50},
        '{100,   50,  0,  0, 2,    5,   60,   95, 40},
        '{2000, 300,  0,  0, 3,   77,  300, 1990, 58}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1: return "R4 code";
            2, 3, 8: return "R5 window";
            4: return "R6 preset";
            5, 6: return "R7 size";
            default: return "R9 hidden";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pix_code == 2'b10, "R1 code", int'(pix_code), 2);
        chk(cur_rgb == 0, "R1 rgb", int'(cur_rgb), 0);
        chk(!mem_rd, "R1 mem_rd", int'(mem_rd), 0);
        chk(!main_pal_we, "R1 main_pal_we", int'(main_pal_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 palette routing
        wr(6, 7);
        pal_we = 1'b1; pal_sel = 1'b0; pal_wdata = 24'(PAL0);
        #1 chk(!main_pal_we, "R10 routed", int'(main_pal_we), 0);
        @(negedge clk);
        pal_sel = 1'b1; pal_wdata = 24'(PAL1);
        @(negedge clk);
        wr(6, 3);
        pal_sel = 1'b0; pal_wdata = 24'h999999;
        #1 chk(main_pal_we, "R10 forwarded", int'(main_pal_we), 1);
        @(negedge clk);
        pal_we = 1'b0;

        // vector table
        for (int i = 0; i < 9; i++) begin
            setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
            do_line(VEC[i][6]);
            sweep(VEC[i][7], VEC[i][8], VEC[i][6], 1'b1, tag_of(i));
        end

        // R11 blanked pixels over a hitting row
        setup(100, 50, 0, 0, 3, 5);
        do_line(60);
        sweep(95, 40, 60, 1'b0, "R11 blank");

        // R8 write without frame pulse keeps the old start
        wr(0, 120);
        do_line(60);
        sweep(95, 60, 60, 1'b1, "R8 held");
        // R8 write in the same cycle as the frame pulse is taken
        reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'd140; frame_start = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; frame_start = 1'b0;
        e_hs = 140;
        do_line(60);
        sweep(130, 80, 60, 1'b1, "R8 same cycle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule